// File: doc/BRIEF.md
# Serial-In Switch Control Register

This block holds the on/off state of a bank of switches. Control bits arrive one at a time on a serial data input, one bit on each rising edge of the clock. The first bit shifted in ends up controlling the highest-numbered switch. A latch sits between the shift register and the switch-enable outputs.

While the latch-enable input is low, the latch passes the shift register straight through, so the outputs track every shift. Raising latch-enable freezes the outputs at their current value. Further shifting then changes only the register until latch-enable drops again.

A serial data output presents the last register stage, so several of these blocks can be chained on a shared clock and latch-enable. A clear input forces every output off at once without touching the register or the latch. When clear drops, the held pattern returns. The usual sequence is to hold latch-enable high, shift in one word per block in the chain, then pulse latch-enable low to commit the new pattern.

Top module: `swctl_serial_latch`

## Requirements
- R1: A synchronous active-high reset clears the shift register and the latch. After reset every switch-enable output is 0 and the serial output is 0.
- R2: On each rising clock edge the register shifts toward the high end: the input bit enters bit 0 and every other bit moves up one place. After WIDTH edges, the first bit shifted in drives output bit WIDTH-1 (most significant bit first).
- R3: If latch-enable is low at a clock edge, the latch takes the register value produced by that edge. After that edge the outputs equal the new register contents (flow-through).
- R4: While latch-enable is high at clock edges, shifting continues but the switch-enable outputs do not change.
- R5: When latch-enable rises, the outputs keep the register value loaded at the last edge on which latch-enable was low.
- R6: The serial output equals register bit WIDTH-1. A bit shifted in appears there after WIDTH clock edges, counting the edge that captured it.
- R7: While clear is high, all switch-enable outputs are 0 regardless of register or latch contents. The gating acts without waiting for a clock edge.
- R8: Clear changes neither the shift register nor the latch, and shifting and latching go on during clear. Once clear is low, the outputs show the latch contents.
- R9: When a second block's serial input is fed from the first block's serial output, with clock, latch-enable and clear shared, shifting 2*WIDTH bits has this result: the first WIDTH bits end up in the second block and the last WIDTH bits stay in the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | Serial control bit, sampled on each rising edge |
| le | input | 1 | Latch-enable: low = outputs follow register, high = outputs held |
| clr | input | 1 | Clear: high forces all outputs off |
| sw_en | output | WIDTH | Switch-enable levels, 1 = switch on |
| sdo | output | 1 | Last register stage, for chaining |

## Verification
A walking one shows which end the first bit lands on and catches a reversed shift direction. An alternating word loaded with latch-enable high, and then committed with a low pulse, separates hold from flow-through. Shifting a second word with latch-enable held high confirms the outputs stay frozen while the serial output keeps moving. Raising clear in the middle of a stream, and dropping it again, shows that the held pattern survives the clear. A second chained instance takes the first block's serial output, which confirms the WIDTH-edge delay end to end.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  localparam int SWCTL_WIDTH = 16;

  typedef enum logic {
    LATCH_FLOW = 1'b0,
    LATCH_HOLD = 1'b1
  } latch_mode_e;
endpackage

// File: rtl/swctl_shift_stage.sv
module swctl_shift_stage #(
  parameter int WIDTH = swctl_pkg::SWCTL_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdi,
  output logic [WIDTH-1:0] sr_q,
  output logic [WIDTH-1:0] sr_next,
  output logic             sdo
);
  localparam int TOP = WIDTH - 1;

  // New bits enter at bit 0, so the first bit sent ends at the top.
  always_comb sr_next = {sr_q[TOP-1:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_next;
  end

  assign sdo = sr_q[TOP];
endmodule

// File: rtl/swctl_hold_latch.sv
module swctl_hold_latch #(
  parameter int WIDTH = swctl_pkg::SWCTL_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] lat_q
);
  import swctl_pkg::*;

  latch_mode_e mode;
  always_comb mode = latch_mode_e'(le);

  // Flow mode loads the value the shift stage produces on this same edge.
  always_ff @(posedge clk) begin
    if (rst)                     lat_q <= '0;
    else if (mode == LATCH_FLOW) lat_q <= d;
  end
endmodule

// File: rtl/swctl_out_gate.sv
module swctl_out_gate #(
  parameter int WIDTH = swctl_pkg::SWCTL_WIDTH
) (
  input  logic             clr,
  input  logic [WIDTH-1:0] lat_q,
  output logic [WIDTH-1:0] sw_en
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sw_en[i] = lat_q[i] & ~clr;
  end
endmodule

// File: rtl/swctl_serial_latch.sv
module swctl_serial_latch #(
  parameter int WIDTH = swctl_pkg::SWCTL_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdi,
  input  logic             le,
  input  logic             clr,
  output logic [WIDTH-1:0] sw_en,
  output logic             sdo
);
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_next;
  logic [WIDTH-1:0] lat_q;

  swctl_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sdi     (sdi),
    .sr_q    (sr_q),
    .sr_next (sr_next),
    .sdo     (sdo)
  );

  swctl_hold_latch #(.WIDTH(WIDTH)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .le    (le),
    .d     (sr_next),
    .lat_q (lat_q)
  );

  swctl_out_gate #(.WIDTH(WIDTH)) u_gate (
    .clr   (clr),
    .lat_q (lat_q),
    .sw_en (sw_en)
  );
endmodule

// File: rtl/swctl_serial_latch_chk.sv
module swctl_serial_latch_chk #(
  parameter int WIDTH = swctl_pkg::SWCTL_WIDTH
) (
  input logic             clk,
  input logic             rst,
  input logic             sdi,
  input logic             le,
  input logic             clr,
  input logic [WIDTH-1:0] sw_en,
  input logic             sdo,
  input logic [WIDTH-1:0] sr_q,
  input logic [WIDTH-1:0] lat_q
);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sw_en == '0 && sdo == 1'b0));

  assert_shift_order_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sr_q == {$past(sr_q[WIDTH-2:0]), $past(sdi)}));

  assert_flow_through_R3: assert property (@(posedge clk) disable iff (rst)
    !le |=> (clr || sw_en == sr_q));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (le && !clr) |=> (clr || $stable(sw_en)));

  assert_serial_out_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sdo == $past(sr_q[WIDTH-2])));

  assert_clear_off_R7: assert property (@(posedge clk) disable iff (rst)
    clr |-> (sw_en == '0));

  assert_clear_release_R8: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (sw_en == lat_q));
endmodule

bind swctl_serial_latch swctl_serial_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .sdi   (sdi),
  .le    (le),
  .clr   (clr),
  .sw_en (sw_en),
  .sdo   (sdo),
  .sr_q  (sr_q),
  .lat_q (lat_q)
);

// File: tb/swctl_serial_latch_test.sv
`timescale 1ns/1ps
module swctl_serial_latch_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi = 1'b0;
  logic le  = 1'b1;
  logic clr = 1'b0;
  logic [W-1:0] sw_en, sw_en2;
  logic sdo, sdo2;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  swctl_serial_latch #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .sdi(sdi), .le(le), .clr(clr),
    .sw_en(sw_en), .sdo(sdo));

  swctl_serial_latch #(.WIDTH(W)) uut_chain (
    .clk(clk), .rst(rst), .sdi(sdo), .le(le), .clr(clr),
    .sw_en(sw_en2), .sdo(sdo2));

  typedef struct {
    logic [W-1:0] sw;
    logic         so;
    logic [W-1:0] sw2;
    string        tag;
  } item_t;

  item_t exp_q[$];

  // Behavioural model of both chained blocks, built from the requirements.
  logic [W-1:0] m_sr = '0, m_lat = '0, m_sr2 = '0, m_lat2 = '0;

  task automatic step(input logic d, input logic l, input logic c, input string tag);
    item_t it;
    logic [W-1:0] n1, n2;
    @(negedge clk);
    sdi = d; le = l; clr = c;
    n1 = {m_sr[W-2:0], d};
    n2 = {m_sr2[W-2:0], m_sr[W-1]};
    m_sr = n1; m_sr2 = n2;
    if (!l) begin m_lat = n1; m_lat2 = n2; end
    it.sw  = c ? '0 : m_lat;
    it.so  = m_sr[W-1];
    it.sw2 = c ? '0 : m_lat2;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic shift_word(input logic [W-1:0] w, input logic l, input logic c, input string tag);
    for (int i = W - 1; i >= 0; i--) step(w[i], l, c, tag);
  endtask

  // Monitor: compare each edge's result against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        checks++;
        if (sw_en !== e.sw) begin
          errors++;
          $display("FAIL %s sw_en actual=%h expected=%h", e.tag, sw_en, e.sw);
        end
        checks++;
        if (sdo !== e.so) begin
          errors++;
          $display("FAIL %s/R6 sdo actual=%b expected=%b", e.tag, sdo, e.so);
        end
        checks++;
        if (sw_en2 !== e.sw2) begin
          errors++;
          $display("FAIL %s/R9 chained sw_en actual=%h expected=%h", e.tag, sw_en2, e.sw2);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (sw_en !== '0 || sdo !== 1'b0 || sw_en2 !== '0) begin
      errors++;
      $display("FAIL R1 reset actual sw=%h sdo=%b expected sw=0 sdo=0", sw_en, sdo);
    end

    // R2/R3: walking one with flow-through; first bit ends at the top.
    shift_word(16'h8000, 1'b0, 1'b0, "R2_R3_walk");
    // R4: load a word with the latch held; outputs stay frozen.
    shift_word(16'hA5C3, 1'b1, 1'b0, "R4_hold");
    // R5: commit with a low pulse, then hold while another word shifts.
    step(1'b1, 1'b0, 1'b0, "R5_commit");
    shift_word(16'h3C96, 1'b1, 1'b0, "R5_keep");
    // R7: clear mid-stream forces outputs off while data keeps moving.
    shift_word(16'hFFFF, 1'b1, 1'b1, "R7_clear");
    // R8: release clear; held pattern is back unchanged.
    step(1'b0, 1'b1, 1'b0, "R8_release");
    // R8: latch updated during clear, visible after release.
    step(1'b1, 1'b0, 1'b1, "R8_latch_in_clear");
    step(1'b0, 1'b1, 1'b0, "R8_show_latch");
    // R9/R6: two words through the chain, then commit both blocks.
    shift_word(16'h1234, 1'b1, 1'b0, "R9_first");
    shift_word(16'hBEEF, 1'b1, 1'b0, "R9_second");
    step(1'b0, 1'b0, 1'b0, "R9_commit");
    shift_word(16'h5A5A, 1'b0, 1'b0, "R3_R6_flow");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule